// File: doc/BRIEF.md
# Zeroizable Master Key Store

This block keeps a 256-bit clearable secret as eight 32-bit words and combines it with a fixed one-time key that arrives on an input port. Software reaches the words and a control register over a simple single-cycle register bus. A select field then picks the master key output: the one-time key alone, the clearable key alone, or the bitwise XOR of the two. A zeroize pulse wipes the clearable key and drops its valid state. The key words cannot be read back.

Whether the clearable key may be used is held by a two-state machine. `ST_EMPTY` means no usable key, and `ST_VALID` means a loaded key. The machine has four named transitions:
- `load_sw`: in software mode, software writes the control register with the valid bit set. This moves `ST_EMPTY` to `ST_VALID`.
- `load_hw`: in hardware mode, a hardware load strobe moves `ST_EMPTY` to `ST_VALID`.
- `drop_sw`: in software mode, software writes the control register with the valid bit cleared. This moves `ST_VALID` to `ST_EMPTY`.
- `wipe`: a zeroize pulse forces `ST_EMPTY` from either state.

In hardware programming mode the valid bit can only be read as status. Software key-word writes and software valid writes are ignored in that mode. A parity bit is kept for each word. When integrity checking is enabled, it flags a word whose contents no longer match the parity taken at load time.

Top module: `zkey_store`

## Requirements
- R1: After reset the control register reads 0 and the machine is in `ST_EMPTY`. The clearable key is all zero, `key_error` and `integrity_err` are 0, and `master_key` equals `otp_key`.
- R2: In software mode, a write to offset i (0 to 7) loads bits [32i+31:32i] of the clearable key on the next clock edge. A read at any key-word offset returns 0.
- R3: The control register sits at offset 8 and reads back as follows:
  - bit 0 is the valid state.
  - bit 1 is the programming mode (0 = software, 1 = hardware).
  - bit 2 is integrity enable.
  - bits [5:4] are the select field.
  - All other bits read as 0.
  - Mode, enable and select take their written values on the next edge.
- R4: In software mode, a control write with bit 0 = 1 takes the machine to `ST_VALID`, and a control write with bit 0 = 0 takes it to `ST_EMPTY`. Whether bit 0 is honoured depends on the mode held before that write.
- R5: In hardware mode, software key-word writes and the valid bit of control writes have no effect. A `hw_load` pulse loads all of `hw_key` into the key and enters `ST_VALID` on the next edge. In software mode `hw_load` is ignored.
- R6: The select field chooses the output. Select 0 and select 1 give `otp_key`, select 2 gives the clearable key, and select 3 gives `otp_key` XOR the clearable key.
- R7: While the machine is in `ST_EMPTY`, the clearable key contributes zero to `master_key`. So select 2 gives all zeros and select 3 gives `otp_key`.
- R8: `key_error` is 1 exactly when the machine is in `ST_EMPTY` and select is 2 or 3.
- R9: A one-cycle `zeroize` pulse clears all eight words and enters `ST_EMPTY` on the next edge. It overrides key writes, `hw_load` and a valid write in the same cycle. The mode, enable and select fields of a same-cycle control write still take effect.
- R10: `integrity_err` stays 0 for a key held intact, whether integrity checking is enabled or disabled.
- R11: Offsets 9 to 15 read as 0, and writes to them change neither the key nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hw_load | input | 1 | Hardware key load strobe |
| hw_key | input | 256 | Key loaded by `hw_load` |
| zeroize | input | 1 | Wipe pulse |
| otp_key | input | 256 | Fixed one-time key |
| master_key | output | 256 | Selected master key |
| key_error | output | 1 | Clearable key selected but not valid |
| integrity_err | output | 1 | Parity mismatch with checking enabled |

## Verification
The assertions assume that the bus, `hw_load` and `zeroize` are driven synchronously and hold still around the clock edge. They also assume that `zeroize` and `hw_load` are single-cycle pulses, and that the `hw_key` value is stable in the cycle `hw_load` is high. The stimulus changes every input only at the falling edge and keeps each strobe high for exactly one cycle. It deliberately places `zeroize` together with a key write, with `hw_load` and with a control write, so that the priority rules are exercised rather than assumed.

// File: rtl/zks_pkg.sv
package zks_pkg;

    typedef enum logic [1:0] {
        SEL_OTP  = 2'd0,
        SEL_RSVD = 2'd1,
        SEL_ZKEY = 2'd2,
        SEL_MIX  = 2'd3
    } key_sel_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_VALID = 1'b1
    } key_state_e;

    localparam int CTRL_VALID_BIT = 0;
    localparam int CTRL_MODE_BIT  = 1;
    localparam int CTRL_INTEG_BIT = 2;
    localparam int CTRL_SEL_LSB   = 4;

endpackage

// File: rtl/zks_keyregs.sv
module zks_keyregs #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    parameter int ADDR_W  = 4,
    localparam int KEY_W  = WORD_W * N_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zeroize,
    input  logic              hw_mode,
    input  logic              hw_load,
    input  logic [KEY_W-1:0]  hw_key,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              integ_en,
    output logic [KEY_W-1:0]  key,
    output logic              integrity_err
);

    logic [N_WORDS-1:0] par_q;
    logic [N_WORDS-1:0] par_bad;

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              sw_hit;

        assign sw_hit = !hw_mode && wr_en && (addr == ADDR_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q    <= '0;
                par_q[gi] <= 1'b0;
            end else if (zeroize) begin
                word_q    <= '0;
                par_q[gi] <= 1'b0;
            end else if (hw_mode && hw_load) begin
                word_q    <= hw_key[gi*WORD_W +: WORD_W];
                par_q[gi] <= ^hw_key[gi*WORD_W +: WORD_W];
            end else if (sw_hit) begin
                word_q    <= wdata;
                par_q[gi] <= ^wdata;
            end
        end

        assign key[gi*WORD_W +: WORD_W] = word_q;
        assign par_bad[gi] = (^word_q) != par_q[gi];
    end

    assign integrity_err = integ_en && (|par_bad);

    // R9: a wipe leaves every word at zero
    p_wipe_clears_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize |=> (key == '0));

    // R5: software word writes are ignored in hardware mode
    p_hw_mode_blocks_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode && wr_en && !hw_load && !zeroize) |=> $stable(key));

    // R11: writes outside the key window leave the key alone
    p_unmapped_no_key_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr >= ADDR_W'(N_WORDS)) && !hw_load && !zeroize) |=> $stable(key));

endmodule

// File: rtl/zks_ctrl.sv
module zks_ctrl
    import zks_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zeroize,
    input  logic              hw_load,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              key_valid,
    output logic              hw_mode,
    output logic              integ_en,
    output key_sel_e          sel,
    output logic [WORD_W-1:0] ctrl_word
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_WORDS);

    key_state_e state_q, state_d;
    logic       ctrl_wr;
    logic       load_sw, load_hw, drop_sw, wipe;

    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
    assign wipe    = zeroize;
    assign load_sw = !hw_mode && ctrl_wr && wdata[CTRL_VALID_BIT];
    assign drop_sw = !hw_mode && ctrl_wr && !wdata[CTRL_VALID_BIT];
    assign load_hw = hw_mode && hw_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wipe)                   state_d = ST_EMPTY;
                else if (load_hw || load_sw) state_d = ST_VALID;
            end
            ST_VALID: begin
                if (wipe || drop_sw) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_mode  <= 1'b0;
            integ_en <= 1'b0;
            sel      <= SEL_OTP;
        end else if (ctrl_wr) begin
            hw_mode  <= wdata[CTRL_MODE_BIT];
            integ_en <= wdata[CTRL_INTEG_BIT];
            sel      <= key_sel_e'(wdata[CTRL_SEL_LSB +: 2]);
        end
    end

    always_comb begin
        key_valid = (state_q == ST_VALID);
        ctrl_word = '0;
        ctrl_word[CTRL_VALID_BIT]     = key_valid;
        ctrl_word[CTRL_MODE_BIT]      = hw_mode;
        ctrl_word[CTRL_INTEG_BIT]     = integ_en;
        ctrl_word[CTRL_SEL_LSB +: 2]  = sel;
    end

    // R9: a wipe always ends in the empty state
    p_wipe_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize |=> !key_valid);

    // R5: the valid bit of a control write is ignored in hardware mode
    p_hw_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode && ctrl_wr && !hw_load && !zeroize) |=> $stable(key_valid));

    // R5: a hardware load in hardware mode validates the key
    p_hw_load_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode && hw_load && !zeroize) |=> key_valid);

    // R4: a software valid write is honoured on the next edge
    p_sw_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_mode && ctrl_wr && !zeroize) |=> (key_valid == $past(wdata[CTRL_VALID_BIT])));

endmodule

// File: rtl/zks_keymux.sv
module zks_keymux
    import zks_pkg::*;
#(
    parameter int KEY_W = 256
) (
    input  logic [KEY_W-1:0] otp_key,
    input  logic [KEY_W-1:0] zkey,
    input  logic             key_valid,
    input  key_sel_e         sel,
    output logic [KEY_W-1:0] master_key,
    output logic             key_error
);

    logic [KEY_W-1:0] zkey_gated;

    assign zkey_gated = key_valid ? zkey : '0;

    always_comb begin
        master_key = otp_key;
        key_error  = 1'b0;
        unique case (sel)
            SEL_OTP, SEL_RSVD: master_key = otp_key;
            SEL_ZKEY: begin
                master_key = zkey_gated;
                key_error  = !key_valid;
            end
            SEL_MIX: begin
                master_key = otp_key ^ zkey_gated;
                key_error  = !key_valid;
            end
            default: master_key = otp_key;
        endcase
    end

endmodule

// File: rtl/zkey_store.sv
module zkey_store
    import zks_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int N_WORDS  = 8,
    localparam int ADDR_W  = $clog2(N_WORDS + 1),
    localparam int KEY_W   = WORD_W * N_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              hw_load,
    input  logic [KEY_W-1:0]  hw_key,
    input  logic              zeroize,
    input  logic [KEY_W-1:0]  otp_key,
    output logic [KEY_W-1:0]  master_key,
    output logic              key_error,
    output logic              integrity_err
);

    logic [KEY_W-1:0]  zkey;
    logic              key_valid, hw_mode, integ_en;
    key_sel_e          sel;
    logic [WORD_W-1:0] ctrl_word;

    zks_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .zeroize   (zeroize),
        .hw_load   (hw_load),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .key_valid (key_valid),
        .hw_mode   (hw_mode),
        .integ_en  (integ_en),
        .sel       (sel),
        .ctrl_word (ctrl_word)
    );

    zks_keyregs #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_keys (
        .clk           (clk),
        .rst_n         (rst_n),
        .zeroize       (zeroize),
        .hw_mode       (hw_mode),
        .hw_load       (hw_load),
        .hw_key        (hw_key),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .integ_en      (integ_en),
        .key           (zkey),
        .integrity_err (integrity_err)
    );

    zks_keymux #(.KEY_W(KEY_W)) u_mux (
        .otp_key    (otp_key),
        .zkey       (zkey),
        .key_valid  (key_valid),
        .sel        (sel),
        .master_key (master_key),
        .key_error  (key_error)
    );

    assign rdata = (addr == ADDR_W'(N_WORDS)) ? ctrl_word : '0;

    // R6: the one-time selections pass the fixed key through
    p_otp_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_OTP) || (sel == SEL_RSVD)) |-> (master_key == otp_key));

    // R7: an empty store never leaks stored words
    p_empty_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && (sel == SEL_ZKEY)) |-> (master_key == '0));

    // R8: an error flag implies the empty state
    p_error_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_error |-> !key_valid);

    // R2: key words are never readable
    p_words_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < ADDR_W'(N_WORDS)) |-> (rdata == '0));

endmodule

// File: tb/zkey_store_bench.sv
`timescale 1ns/1ps
module zkey_store_bench;

    localparam int WW = 32;
    localparam int NW = 8;
    localparam int KW = WW * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] rdata;
    logic          hw_load = 1'b0;
    logic [KW-1:0] hw_key = '0;
    logic          zeroize = 1'b0;
    logic [KW-1:0] otp_key = '0;
    logic [KW-1:0] master_key;
    logic          key_error;
    logic          integrity_err;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    zkey_store u_zkey_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hw_load(hw_load), .hw_key(hw_key), .zeroize(zeroize),
        .otp_key(otp_key), .master_key(master_key), .key_error(key_error),
        .integrity_err(integrity_err)
    );

    // reference model
    logic [KW-1:0] m_key;
    bit            m_valid, m_hw, m_integ;
    bit [1:0]      m_sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_key = '0; m_valid = 0; m_hw = 0; m_integ = 0; m_sel = 0;
        end else begin
            bit old_hw;
            old_hw = m_hw;
            if (zeroize) begin
                m_key = '0;
                m_valid = 0;
            end else begin
                if (old_hw && hw_load) begin
                    m_key = hw_key;
                    m_valid = 1;
                end else if (!old_hw && wr_en && addr < NW) begin
                    m_key[addr*WW +: WW] = wdata;
                end
                if (!old_hw && wr_en && addr == NW) m_valid = wdata[0];
            end
            if (wr_en && addr == NW) begin
                m_hw = wdata[1];
                m_integ = wdata[2];
                m_sel = wdata[5:4];
            end
        end
    end

    function automatic logic [KW-1:0] exp_master();
        logic [KW-1:0] z;
        z = m_valid ? m_key : '0;
        case (m_sel)
            2'd2:    return z;
            2'd3:    return otp_key ^ z;
            default: return otp_key;
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        if (!done) begin
            logic [WW-1:0] e_rd;
            logic          e_err;
            logic [KW-1:0] e_mk;
            e_mk  = exp_master();
            e_err = !m_valid && m_sel[1];
            e_rd  = '0;
            if (addr == NW) e_rd = {26'd0, m_sel, 1'b0, m_integ, m_hw, m_valid};
            n_chk++;
            if (master_key !== e_mk || key_error !== e_err ||
                integrity_err !== 1'b0 || rdata !== e_rd) begin
                n_bad++;
                $display("FAIL %s: mk=%h err=%b ierr=%b rd=%h exp mk=%h err=%b ierr=0 rd=%h",
                         cur_req, master_key, key_error, integrity_err, rdata,
                         e_mk, e_err, e_rd);
            end
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [WW-1:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [WW-1:0] ctl(bit [1:0] s, bit integ, bit hw, bit v);
        return {26'd0, s, 1'b0, integ, hw, v};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            otp_key[i*WW +: WW] = 32'hA5A50000 + i;
            hw_key[i*WW +: WW]  = 32'h3C000000 + (i << 8) + i;
        end
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(2, 4'd8);

        cur_req = "R2";
        for (int i = 0; i < NW; i++) bus_wr(4'(i), 32'h1111_0000 * (i + 1) + 32'h0F0F);
        for (int i = 0; i < NW; i++) idle(1, 4'(i));

        cur_req = "R8";
        bus_wr(4'd8, ctl(2'd2, 0, 0, 0));
        idle(2, 4'd8);
        cur_req = "R7";
        bus_wr(4'd8, ctl(2'd3, 0, 0, 0));
        idle(1, 4'd8);

        cur_req = "R4";
        bus_wr(4'd8, ctl(2'd2, 0, 0, 1));
        idle(2, 4'd8);
        cur_req = "R6";
        bus_wr(4'd8, ctl(2'd3, 0, 0, 1));
        idle(1, 4'd8);
        bus_wr(4'd8, ctl(2'd1, 0, 0, 1));
        idle(1, 4'd8);
        bus_wr(4'd8, ctl(2'd0, 1, 0, 1));
        idle(1, 4'd8);
        cur_req = "R10";
        bus_wr(4'd8, ctl(2'd2, 1, 0, 1));
        idle(2, 4'd8);

        cur_req = "R11";
        bus_wr(4'd9, 32'hFFFF_FFFF);
        bus_wr(4'd15, 32'hFFFF_FFFF);
        idle(1, 4'd9);
        idle(1, 4'd8);

        cur_req = "R4";
        bus_wr(4'd8, ctl(2'd2, 0, 0, 0));
        idle(1, 4'd8);
        bus_wr(4'd8, ctl(2'd3, 0, 0, 1));
        idle(1, 4'd8);

        cur_req = "R9";
        addr = 4'd3; wdata = 32'hDEAD_BEEF; wr_en = 1; zeroize = 1;
        @(negedge clk);
        wr_en = 0; zeroize = 0;
        idle(2, 4'd8);
        bus_wr(4'd8, ctl(2'd2, 0, 0, 1));
        idle(1, 4'd8);

        cur_req = "R5";
        hw_load = 1;
        @(negedge clk);
        hw_load = 0;
        bus_wr(4'd8, ctl(2'd2, 0, 1, 0));
        bus_wr(4'd2, 32'h0BAD_0BAD);
        bus_wr(4'd8, ctl(2'd2, 0, 1, 1));
        idle(1, 4'd8);
        hw_load = 1;
        @(negedge clk);
        hw_load = 0;
        bus_wr(4'd5, 32'h5555_AAAA);
        bus_wr(4'd8, ctl(2'd3, 1, 1, 0));
        idle(2, 4'd8);

        cur_req = "R9";
        zeroize = 1; hw_load = 1;
        @(negedge clk);
        zeroize = 0; hw_load = 0;
        idle(2, 4'd8);
        hw_load = 1;
        @(negedge clk);
        hw_load = 0;
        idle(1, 4'd8);
        addr = 4'd8; wdata = ctl(2'd2, 1, 0, 1); wr_en = 1; zeroize = 1;
        @(negedge clk);
        wr_en = 0; zeroize = 0;
        idle(2, 4'd8);

        cur_req = "R3";
        bus_wr(4'd8, 32'hFFFF_FFC0 | ctl(2'd1, 1, 1, 0));
        idle(1, 4'd8);
        bus_wr(4'd8, 32'd0);
        idle(1, 4'd8);

        cur_req = "R1";
        rst_n = 0;
        idle(2, 4'd8);
        rst_n = 1;
        idle(2, 4'd8);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule